// File: doc/BRIEF.md
# Pipelined Non-Restoring Integer Divider

This block divides an unsigned dividend by an unsigned divisor. The divisor is a run-time value and may be any number, including values that are not powers of two. The division loop is fully unrolled. Each unrolled iteration produces one quotient bit. A parameter sets how many iterations are chained between pipeline registers, which trades clock-cycle latency against combinational depth. The block accepts a new operand pair on every clock, so when the pipeline is full it returns one finished result per clock.

Every iteration either adds or subtracts the divisor. It subtracts when the running partial remainder is non-negative and adds when it is negative. No stage compares first and then selects a result. Each quotient bit is the inverse of the sign of the partial remainder it produced. One correction register at the end adds the divisor back when the last partial remainder is negative. Each operation carries its own divisor, valid flag and zero-divisor flag through the pipeline, so the operations in flight never interfere with one another. The latency is fixed at ceil(N / bits-per-stage) + 1 cycles, which is 5 cycles at the default settings.

Top module: `pnr_divider`

## Requirements
- R1: For a non-zero divisor, `out_quotient` equals floor(dividend / divisor).
- R2: For a non-zero divisor, `out_remainder` equals dividend mod divisor, so it always satisfies 0 <= remainder < divisor.
- R3: `out_valid` rises exactly ceil(N/BPS)+1 clock cycles after the cycle in which `in_valid` was sampled high (5 cycles for N=16, BPS=4), and this latency never changes.
- R4: Operations issued on consecutive clocks produce results on consecutive clocks, in issue order.
- R5: Each result is computed with the divisor that was presented together with its own dividend, even when the divisor changes on every clock.
- R6: A zero divisor sets `out_div_zero` to 1 with that result, drives the quotient to all ones, and makes the remainder equal to the dividend.
- R7: `out_div_zero` is 0 on every result whose divisor was non-zero.
- R8: After reset is released, `out_valid` stays 0 until the first issued operation arrives.
- R9: A cycle with `in_valid` low produces no result, and the gaps between issued operations are kept at the output.
- R10: The boundary cases give the exact results: dividend smaller than divisor gives quotient 0 and remainder equal to the dividend; all-ones divided by 1; all-ones divided by all-ones; a dividend of 0.
- R11: Inside the pipeline, every registered partial remainder of a non-zero-divisor operation stays within [-divisor, divisor).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is present this cycle |
| in_dividend | input | N | Unsigned dividend |
| in_divisor | input | N | Unsigned divisor |
| out_valid | output | 1 | Result is present this cycle |
| out_quotient | output | N | Unsigned quotient |
| out_remainder | output | N | Unsigned remainder |
| out_div_zero | output | 1 | The result came from a zero divisor |

## Verification
The hardest situation to reach is a full pipeline in which every operation in flight has a different divisor, and some of those divisors are zero. In that state each stage has to add or subtract its own operand's divisor and never a neighbour's. The stimulus creates it by issuing long back-to-back runs from a bench-side LFSR, with the divisor changed on every clock. Zero divisors and boundary operands are spliced into the runs, and bubble patterns are mixed in so that valid and invalid slots alternate at several depths.

// File: rtl/pnr_div_pkg.sv
package pnr_div_pkg;

    // Number of register stages needed for n quotient bits at b bits per stage.
    function automatic int stage_count(input int n, input int b);
        return (n + b - 1) / b;
    endfunction

    // Quotient bits resolved inside stage s; the last stage takes the leftover.
    function automatic int bits_in_stage(input int n, input int b, input int s);
        int last;
        last = stage_count(n, b) - 1;
        if (s == last)
            return n - last * b;
        return b;
    endfunction

endpackage

// File: rtl/pnr_div_step.sv
// One unrolled non-restoring iteration: shift one dividend bit into the
// partial remainder, then subtract (remainder >= 0) or add (remainder < 0).
module pnr_div_step #(
    parameter int N = 16,
    parameter int W = N + 2
) (
    input  logic [W-1:0] rem_i,
    input  logic [N-1:0] dq_i,
    input  logic [N-1:0] dvs_i,
    output logic [W-1:0] rem_o,
    output logic [N-1:0] dq_o
);
    logic [W-1:0] shifted;
    logic [W-1:0] dvs_ext;
    logic         qbit;

    always_comb begin
        shifted = {rem_i[W-2:0], dq_i[N-1]};
        dvs_ext = {2'b00, dvs_i};
        if (rem_i[W-1])
            rem_o = shifted + dvs_ext;
        else
            rem_o = shifted - dvs_ext;
        qbit = ~rem_o[W-1];
        dq_o = {dq_i[N-2:0], qbit};
    end
endmodule

// File: rtl/pnr_div_stage.sv
// A group of NB chained iterations followed by one pipeline register.
module pnr_div_stage #(
    parameter int N  = 16,
    parameter int NB = 4,
    parameter int W  = N + 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic         dz_i,
    input  logic [W-1:0] rem_i,
    input  logic [N-1:0] dq_i,
    input  logic [N-1:0] dvs_i,
    output logic         vld_o,
    output logic         dz_o,
    output logic [W-1:0] rem_o,
    output logic [N-1:0] dq_o,
    output logic [N-1:0] dvs_o
);
    typedef struct packed {
        logic         vld;
        logic         dz;
        logic [W-1:0] rem;
        logic [N-1:0] dq;
        logic [N-1:0] dvs;
    } stg_t;

    stg_t stg_d, stg_q;

    logic [W-1:0] rem_c [NB+1];
    logic [N-1:0] dq_c  [NB+1];

    assign rem_c[0] = rem_i;
    assign dq_c[0]  = dq_i;

    for (genvar j = 0; j < NB; j++) begin : g_iter
        pnr_div_step #(.N(N), .W(W)) u_step (
            .rem_i (rem_c[j]),
            .dq_i  (dq_c[j]),
            .dvs_i (dvs_i),
            .rem_o (rem_c[j+1]),
            .dq_o  (dq_c[j+1])
        );
    end

    always_comb begin
        stg_d     = stg_q;
        stg_d.vld = vld_i;
        stg_d.dz  = dz_i;
        stg_d.rem = rem_c[NB];
        stg_d.dq  = dq_c[NB];
        stg_d.dvs = dvs_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            stg_q <= '0;
        else
            stg_q <= stg_d;
    end

    assign vld_o = stg_q.vld;
    assign dz_o  = stg_q.dz;
    assign rem_o = stg_q.rem;
    assign dq_o  = stg_q.dq;
    assign dvs_o = stg_q.dvs;

    // Non-restoring invariant: partial remainder stays in [-D, D).
    p_rem_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_q.vld && !stg_q.dz) |->
            (($signed(stg_q.rem) <  $signed({2'b00, stg_q.dvs})) &&
             ($signed(stg_q.rem) >= -$signed({2'b00, stg_q.dvs}))));

    // The zero flag always agrees with the divisor that travels with it.
    p_dz_tracks_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stg_q.vld |-> (stg_q.dz == (stg_q.dvs == '0)));
endmodule

// File: rtl/pnr_divider.sv
module pnr_divider #(
    parameter int N   = 16,
    parameter int BPS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [N-1:0] in_dividend,
    input  logic [N-1:0] in_divisor,
    output logic         out_valid,
    output logic [N-1:0] out_quotient,
    output logic [N-1:0] out_remainder,
    output logic         out_div_zero
);
    import pnr_div_pkg::*;

    localparam int W    = N + 2;
    localparam int NSTG = stage_count(N, BPS);

    typedef struct packed {
        logic         vld;
        logic         dz;
        logic [W-1:0] rem;
        logic [N-1:0] quo;
        logic [N-1:0] dvs;
    } fin_t;

    logic         vld_a [NSTG+1];
    logic         dz_a  [NSTG+1];
    logic [W-1:0] rem_a [NSTG+1];
    logic [N-1:0] dq_a  [NSTG+1];
    logic [N-1:0] dvs_a [NSTG+1];

    assign vld_a[0] = in_valid;
    assign dz_a[0]  = (in_divisor == '0);
    assign rem_a[0] = '0;
    assign dq_a[0]  = in_dividend;
    assign dvs_a[0] = in_divisor;

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        localparam int NB = bits_in_stage(N, BPS, s);
        pnr_div_stage #(.N(N), .NB(NB), .W(W)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .vld_i (vld_a[s]),
            .dz_i  (dz_a[s]),
            .rem_i (rem_a[s]),
            .dq_i  (dq_a[s]),
            .dvs_i (dvs_a[s]),
            .vld_o (vld_a[s+1]),
            .dz_o  (dz_a[s+1]),
            .rem_o (rem_a[s+1]),
            .dq_o  (dq_a[s+1]),
            .dvs_o (dvs_a[s+1])
        );
    end

    fin_t fin_d, fin_q;

    // Final correction: a negative remainder gets the divisor added back once.
    always_comb begin
        fin_d     = fin_q;
        fin_d.vld = vld_a[NSTG];
        fin_d.dz  = dz_a[NSTG];
        fin_d.quo = dq_a[NSTG];
        fin_d.dvs = dvs_a[NSTG];
        if (rem_a[NSTG][W-1])
            fin_d.rem = rem_a[NSTG] + {2'b00, dvs_a[NSTG]};
        else
            fin_d.rem = rem_a[NSTG];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            fin_q <= '0;
        else
            fin_q <= fin_d;
    end

    assign out_valid     = fin_q.vld;
    assign out_div_zero  = fin_q.dz;
    assign out_quotient  = fin_q.quo;
    assign out_remainder = fin_q.rem[N-1:0];

    // Corrected remainder is non-negative and below the divisor.
    p_rem_below_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_q.vld && !fin_q.dz) |->
            (!fin_q.rem[W-1] && (fin_q.rem < {2'b00, fin_q.dvs})));

    // quotient * divisor + remainder never leaves the N-bit range.
    p_recombine_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_q.vld && !fin_q.dz) |->
            (({{N{1'b0}}, fin_q.quo} * {{N{1'b0}}, fin_q.dvs}
              + {{N{1'b0}}, fin_q.rem[N-1:0]}) < (2*N)'(1) << N));

    // Zero divisor: quotient saturates to all ones.
    p_dz_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_div_zero) |-> (&out_quotient));

    // Outputs are never unknown once reset has been applied.
    p_valid_known_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(out_valid));
endmodule

// File: tb/tb_pnr_divider.sv
module tb_pnr_divider;
    localparam int N   = 16;
    localparam int BPS = 4;
    localparam int LAT = (N + BPS - 1) / BPS + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [N-1:0] in_dividend = '0;
    logic [N-1:0] in_divisor = '0;
    logic         out_valid;
    logic [N-1:0] out_quotient;
    logic [N-1:0] out_remainder;
    logic         out_div_zero;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [N-1:0] exp_q [$];
    logic [N-1:0] exp_r [$];
    logic         exp_z [$];
    int           exp_c [$];
    string        exp_t [$];

    pnr_divider #(.N(N), .BPS(BPS)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_dividend   (in_dividend),
        .in_divisor    (in_divisor),
        .out_valid     (out_valid),
        .out_quotient  (out_quotient),
        .out_remainder (out_remainder),
        .out_div_zero  (out_div_zero)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Output monitor: every result is compared with the oldest expected entry.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected result", 32'(out_valid), 32'd0);
            end else begin
                automatic logic [N-1:0] q = exp_q.pop_front();
                automatic logic [N-1:0] r = exp_r.pop_front();
                automatic logic         z = exp_z.pop_front();
                automatic int           c = exp_c.pop_front();
                automatic string        t = exp_t.pop_front();
                check({t, " quotient R1"},  32'(out_quotient), 32'(q));
                check({t, " remainder R2"}, 32'(out_remainder), 32'(r));
                check({t, " zero flag R7"}, 32'(out_div_zero), 32'(z));
                check({t, " latency R3"},   32'(cyc - c), 32'(LAT));
            end
        end
    end

    task automatic issue(input logic [N-1:0] a, input logic [N-1:0] b, input string tag);
        @(negedge clk);
        in_valid    = 1'b1;
        in_dividend = a;
        in_divisor  = b;
        exp_q.push_back(b == '0 ? '1 : a / b);
        exp_r.push_back(b == '0 ? a : a % b);
        exp_z.push_back(b == '0);
        exp_c.push_back(cyc);
        exp_t.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid    = 1'b0;
            in_dividend = '1;
            in_divisor  = '0;
        end
    endtask

    task automatic drain(input string tag);
        idle(LAT + 3);
        check({tag, " all results returned R4"}, 32'(exp_q.size()), 32'd0);
    endtask

    function automatic logic [15:0] step_lfsr(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 valid in reset", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        idle(LAT + 2);
        check("R8 valid after reset", 32'(out_valid), 32'd0);
    endtask

    task automatic t_basic();
        issue(16'd100, 16'd7, "R1 basic");
        idle(LAT + 1);
        issue(16'd1000, 16'd10, "R1 exact");
        issue(16'd12345, 16'd321, "R2 mixed");
        issue(16'd40000, 16'd3, "R7 large");
        drain("R1");
    endtask

    task automatic t_back_to_back();
        for (int i = 0; i < 200; i++) begin
            lfsr = step_lfsr(lfsr);
            begin
                automatic logic [N-1:0] a = lfsr;
                automatic logic [N-1:0] b;
                lfsr = step_lfsr(lfsr);
                b = (i % 3 == 0) ? (lfsr >> (i % 13)) : lfsr;
                if (i % 29 == 0) b = '0;
                issue(a, b, "R5 own divisor");
            end
        end
        drain("R4");
    endtask

    task automatic t_zero();
        issue(16'd0, 16'd0, "R6 zero by zero");
        issue(16'hBEEF, 16'd0, "R6 dz");
        issue(16'hBEEF, 16'd1, "R7 after dz");
        issue(16'hFFFF, 16'd0, "R6 ones");
        drain("R6");
    endtask

    task automatic t_bubbles();
        for (int g = 1; g <= 4; g++) begin
            issue(16'(g * 977), 16'(g + 2), "R9 bubble");
            idle(g);
        end
        for (int i = 0; i < 10; i++) begin
            issue(16'(i * 5003), 16'(i * 7 + 1), "R9 alt");
            idle(1);
        end
        drain("R9");
    endtask

    task automatic t_edges();
        issue(16'd5, 16'd9, "R10 small dividend");
        issue(16'hFFFF, 16'd1, "R10 ones by one");
        issue(16'hFFFF, 16'hFFFF, "R10 ones by ones");
        issue(16'd0, 16'd123, "R10 zero dividend");
        issue(16'hFFFE, 16'hFFFF, "R10 just below");
        issue(16'h8000, 16'h8000, "R10 msb");
        issue(16'hFFFF, 16'h8001, "R10 half");
        drain("R10");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_back_to_back();
        t_zero();
        t_bubbles();
        t_edges();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule